// File: doc/BRIEF.md
# Rotating-Lamp Reaction Guessing Game

This block is a synchronous Moore state machine behind a four-button reaction game. Four lamps light one at a time, in a fixed rotation. The player tries to press the button that sits next to the lamp that is lit. If exactly that one button is pressed, the machine enters a success state. Any other button pattern enters an error state, and the error indicator is raised there. Either result is held for as long as any button stays down. When every button has been released, the game restarts from the first lamp.

The base clock runs faster than a human-paced game would need. The rotation therefore does not step on every edge. It steps only on pacing pulses from an internal linear feedback shift register, so each lamp stays lit for an unpredictable number of cycles. The buttons are sampled on every edge, whether or not a pacing pulse is present, so a press is never lost. The button inputs are assumed to be already debounced and synchronous to the clock.

Top module: `lamp_guess_game`

## Requirements
- R1: While reset is asserted (rst_n low), lamp_o is 4'b0001 (first lamp) and err_o is 0. The pacing register returns to its seed, LFSR_SEED = 8'h01.
- R2: At most one of the five indicator outputs {lamp_o, err_o} is high at any time.
- R3: In a lamp state with btn_i == 0, lamp_o moves one place, 0001→0010→0100→1000→0001, on an edge where the pacing pulse is high. On any other edge it holds.
- R4: The pacing register is 8 bits wide and advances on every edge. The new bit 0 is the XOR of bits 7, 5, 4 and 3, and the other bits shift up by one. The pacing pulse is high when bits [1:0] are both 1. As a result, any 255 consecutive idle edges contain exactly 64 lamp steps.
- R5: In a lamp state, if btn_i equals lamp_o (btn_i[k] pairs with lamp_o[k]), the next edge enters the success state: lamp_o is 0 and err_o is 0.
- R6: In a lamp state, any nonzero btn_i other than lamp_o enters the error state on the next edge. This includes the right button pressed together with others. In the error state lamp_o is 0 and err_o is 1.
- R7: The success and error states are held while btn_i != 0. The first edge with btn_i == 0 returns the machine to the first lamp (lamp_o = 0001, err_o = 0).
- R8: A press is evaluated on every edge and takes priority over a pacing pulse on the same edge.
- R9: A rotation step changes exactly one bit of the 3-bit state code. The lamp codes are 000, 001, 011 and 010, success is 100 and error is 101. An unused code returns to the first lamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | 4 | Button levels; bit k pairs with lamp k |
| lamp_o | output | 4 | One-hot lamp drive; all zero in a result state |
| err_o | output | 1 | High in the error state only |

## Verification
On every cycle the assertions check the following:
- the indicators stay one-hot or all off;
- an idle lamp state steps only on a pacing pulse and otherwise holds;
- a correct press leads to success and a wrong or multiple press leads to error;
- a result state is held while a button is down, and releasing the buttons returns to the first lamp;
- each rotation step flips a single state bit;
- the pacing register never reaches zero.

The bench runs its own model of the pacing sequence, so only its scenarios can show:
- the exact cycle-by-cycle lamp timing across long idle stretches;
- the count of 64 steps in 255 idle cycles;
- that a press on a pulse edge wins over the step;
- that a mid-game reset restarts the rotation and the pacing sequence.

// File: rtl/lgg_pkg.sv
package lgg_pkg;

  localparam int LAMPS = 4;

  typedef enum logic [2:0] {
    ST_L1  = 3'b000,
    ST_L2  = 3'b001,
    ST_L3  = 3'b011,
    ST_L4  = 3'b010,
    ST_OK  = 3'b100,
    ST_ERR = 3'b101
  } game_state_e;

  function automatic logic [LAMPS-1:0] lamp_of(game_state_e s);
    case (s)
      ST_L1:   return 4'b0001;
      ST_L2:   return 4'b0010;
      ST_L3:   return 4'b0100;
      ST_L4:   return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic is_lamp_state(game_state_e s);
    return (s == ST_L1) || (s == ST_L2) || (s == ST_L3) || (s == ST_L4);
  endfunction

  function automatic game_state_e rotate_state(game_state_e s);
    case (s)
      ST_L1:   return ST_L2;
      ST_L2:   return ST_L3;
      ST_L3:   return ST_L4;
      default: return ST_L1;
    endcase
  endfunction

  // Full transition rule: a press outranks a pacing step; results wait for release.
  function automatic game_state_e judge(game_state_e s, logic [LAMPS-1:0] btn,
                                        logic step);
    case (s)
      ST_L1, ST_L2, ST_L3, ST_L4: begin
        if (btn == '0)             return step ? rotate_state(s) : s;
        else if (btn == lamp_of(s)) return ST_OK;
        else                        return ST_ERR;
      end
      ST_OK, ST_ERR: return (btn != '0) ? s : ST_L1;
      default:       return ST_L1;
    endcase
  endfunction

endpackage

// File: rtl/lgg_pacer.sv
module lgg_pacer #(
  parameter int          W         = 8,
  parameter logic [W-1:0] TAPS      = 8'b1011_1000,
  parameter logic [W-1:0] SEED      = 8'h01,
  parameter logic [W-1:0] PACE_MASK = 8'h03
) (
  input  logic clk,
  input  logic rst_n,
  output logic step_o
);

  logic [W-1:0] shreg_q;

  function automatic logic [W-1:0] lfsr_adv(logic [W-1:0] q);
    return {q[W-2:0], ^(q & TAPS)};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= SEED;
    else        shreg_q <= lfsr_adv(shreg_q);
  end

  assign step_o = ((shreg_q & PACE_MASK) == PACE_MASK);

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shreg_q != '0);

endmodule

// File: rtl/lgg_fsm.sv
module lgg_fsm
  import lgg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LAMPS-1:0] btn_i,
  input  logic             step_i,
  output game_state_e      state_o
);

  game_state_e state_q;
  game_state_e state_d;
  logic        in_lamp;
  logic        btn_any;

  assign in_lamp = is_lamp_state(state_q);
  assign btn_any = |btn_i;
  assign state_d = judge(state_q, btn_i, step_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_L1;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R9
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lamp && !btn_any && step_i) |=> ($countones(state_q ^ $past(state_q)) == 1));

  // R8
  press_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lamp && btn_any && step_i) |=> !is_lamp_state(state_q));

endmodule

// File: rtl/lgg_lamp_drv.sv
module lgg_lamp_drv
  import lgg_pkg::*;
(
  input  game_state_e      state_i,
  output logic [LAMPS-1:0] lamp_o,
  output logic             err_o
);

  assign lamp_o = lamp_of(state_i);
  assign err_o  = (state_i == ST_ERR);

endmodule

// File: rtl/lamp_guess_game.sv
module lamp_guess_game
  import lgg_pkg::*;
#(
  parameter int          LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'b1011_1000,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01,
  parameter logic [LFSR_W-1:0] PACE_MASK = 8'h03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] btn_i,
  output logic [3:0] lamp_o,
  output logic       err_o
);

  logic        pace_step;
  game_state_e cur_state;
  logic        lamp_lit;
  logic        in_result;

  lgg_pacer #(
    .W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED), .PACE_MASK(PACE_MASK)
  ) pacer_i (
    .clk(clk), .rst_n(rst_n), .step_o(pace_step)
  );

  lgg_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .step_i(pace_step), .state_o(cur_state)
  );

  lgg_lamp_drv drv_i (
    .state_i(cur_state), .lamp_o(lamp_o), .err_o(err_o)
  );

  assign lamp_lit  = |lamp_o;
  assign in_result = !lamp_lit;

  // R2
  indicator_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lamp_o, err_o}));

  // R3
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_lit && btn_i == 4'b0 && pace_step) |=> (lamp_o == {$past(lamp_o[2:0]), $past(lamp_o[3])}));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_lit && btn_i == 4'b0 && !pace_step) |=> $stable(lamp_o));

  // R5
  hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_lit && btn_i == lamp_o) |=> (lamp_o == 4'b0 && !err_o));

  // R6
  miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_lit && btn_i != 4'b0 && btn_i != lamp_o) |=> (lamp_o == 4'b0 && err_o));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_result && btn_i != 4'b0) |=> ($stable(err_o) && lamp_o == 4'b0));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_result && btn_i == 4'b0) |=> (lamp_o == 4'b0001 && !err_o));

endmodule

// File: tb/lamp_guess_game_tb_top.sv
module lamp_guess_game_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] btn = 4'b0;
  logic [3:0] lamp_o;
  logic       err_o;

  int n_chk  = 0;
  int n_fail = 0;
  string last_tag = "R1";

  always #10 clk = ~clk;

  lamp_guess_game dut_i (
    .clk(clk), .rst_n(rst_n), .btn_i(btn), .lamp_o(lamp_o), .err_o(err_o)
  );

  // Reference model: st 0..3 lamp index, 4 success, 5 error.
  logic [7:0] m_lfsr;
  int         m_st;
  logic       m_step;
  logic [3:0] m_lamp;
  logic       m_err;

  assign m_step = m_lfsr[0] & m_lfsr[1];
  assign m_lamp = (m_st < 4) ? (4'b0001 << m_st) : 4'b0000;
  assign m_err  = (m_st == 5);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lfsr <= 8'h01;
      m_st   <= 0;
    end else begin
      m_lfsr <= {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
      if (m_st >= 4)          m_st <= (btn != 4'b0) ? m_st : 0;
      else if (btn == 4'b0)   m_st <= m_step ? (m_st + 1) % 4 : m_st;
      else if (btn == m_lamp) m_st <= 4;
      else                    m_st <= 5;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick_check();
    @(negedge clk);
    chk({lamp_o, err_o} == {m_lamp, m_err}, last_tag, {lamp_o, err_o}, {m_lamp, m_err});
  endtask

  task automatic drive(input logic [3:0] b);
    btn = b;
    if (m_st >= 4)       last_tag = "R7";
    else if (b == 4'b0)  last_tag = "R3_R4";
    else if (b == m_lamp) last_tag = m_step ? "R8" : "R5";
    else                 last_tag = "R6";
  endtask

  // Vector: {mode[1:0], btn[3:0], expect[1:0], cycles[7:0]}
  // mode 0 fixed btn, 1 press lit lamp, 2 press neighbour; expect 0 none, 1 ok, 2 err
  localparam int NV = 13;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 4'b0000, 2'd0, 8'd40},
    {2'd1, 4'b0000, 2'd1, 8'd5},
    {2'd0, 4'b0000, 2'd0, 8'd3},
    {2'd2, 4'b0000, 2'd2, 8'd4},
    {2'd0, 4'b0000, 2'd0, 8'd20},
    {2'd0, 4'b1111, 2'd2, 8'd3},
    {2'd0, 4'b0000, 2'd0, 8'd10},
    {2'd1, 4'b0000, 2'd1, 8'd1},
    {2'd0, 4'b0000, 2'd0, 8'd30},
    {2'd0, 4'b0011, 2'd2, 8'd2},
    {2'd0, 4'b0000, 2'd0, 8'd50},
    {2'd1, 4'b0000, 2'd1, 8'd8},
    {2'd0, 4'b0000, 2'd0, 8'd5}
  };

  initial begin : wdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [3:0] b;
    int changes;
    logic [3:0] prev;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(lamp_o == 4'b0001 && !err_o, "R1", {lamp_o, err_o}, 5'b00010);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < int'(VEC[v][7:0]); c++) begin
        tick_check();
        if (c == 1 && VEC[v][9:8] == 2'd1)
          chk(lamp_o == 4'b0 && !err_o, "R5", {lamp_o, err_o}, 0);
        if (c == 1 && VEC[v][9:8] == 2'd2)
          chk(lamp_o == 4'b0 && err_o, "R6", {lamp_o, err_o}, 1);
        if (c == 0) begin
          case (VEC[v][15:14])
            2'd1:    b = m_lamp;
            2'd2:    b = {m_lamp[2:0], m_lamp[3]};
            default: b = VEC[v][13:10];
          endcase
          drive(b);
        end
      end
    end

    // R7: release returns to first lamp
    tick_check(); drive(4'b0);
    tick_check();
    chk(lamp_o == 4'b0001 || m_st < 4, "R7", lamp_o, 4'b0001);

    // R8: press on an edge carrying a pacing pulse
    do begin tick_check(); if (!(m_step && m_st < 4)) drive(4'b0); end
    while (!(m_step && m_st < 4));
    drive(m_lamp);
    tick_check();
    chk(lamp_o == 4'b0 && !err_o, "R8", {lamp_o, err_o}, 0);
    drive(4'b0);
    tick_check();
    chk(lamp_o == 4'b0001 && !err_o, "R7", {lamp_o, err_o}, 5'b00010);

    // R4: 255 idle edges contain exactly 64 steps
    changes = 0;
    prev = lamp_o;
    for (int i = 0; i < 255; i++) begin
      tick_check();
      if (lamp_o != prev) changes++;
      prev = lamp_o;
    end
    chk(changes == 64, "R4", changes, 64);

    // R1: mid-game reset from the error state
    drive(4'b0110);
    tick_check();
    chk(err_o == 1'b1, "R6", err_o, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(lamp_o == 4'b0001 && !err_o, "R1", {lamp_o, err_o}, 5'b00010);
    btn = 4'b0;
    last_tag = "R1";
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 60; i++) begin
      tick_check(); drive(4'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule